// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave has left stuck, typically with SDA held low in the middle of a byte. The host pulses a trigger before normal traffic starts or after it detects a hang. The sequencer then takes both open-drain pins away from the byte engine and lets both lines float high. It toggles the clock nine times while watching the data line. If data was high at least once, it generates a START and then a STOP with the clock line left high for the whole time, and waits out the bus-free interval.

The clock stays high between START and STOP on purpose. If SCL dropped between them, some slaves would read that as the start of a new transfer and pull SDA low again. At the end the block gives a one-cycle completion strobe. With that strobe it reports whether recovery worked and whether either line was found low just before the START.

When the sequencer is idle, the byte engine's output enables pass straight to the pins. While the sequencer is busy, it owns both pins.

Top module: `i2c_bus_unwedge`

## Requirements
- R1: When idle (busy low), the pin enables `scl_oe_o`/`sda_oe_o` equal the engine enables `eng_scl_oe_i`/`eng_sda_oe_i`. While busy, only the sequencer drives them. An enable of 1 pulls the line low; 0 releases it.
- R2: A `start_i` pulse while idle raises busy on the next cycle. For the first HALF_CYC busy cycles both enables are 0, so both lines float high.
- R3: The sequencer then makes exactly N_PULSES (default nine) clock cycles. In each one, SCL is pulled low for HALF_CYC cycles and then released for HALF_CYC cycles, so SCL is driven low for N_PULSES*HALF_CYC cycles in total.
- R4: SDA is sampled in the last cycle of each released-SCL phase. A sticky flag records any high sample. Clocking always runs all N_PULSES cycles, even after a high sample.
- R5: If no sample was high, the run ends with done=1, ok=0 and warn=0, and SDA is never driven during the run.
- R6: After the last clock, if SDA was seen high, SCL and SDA are both checked. If either is low, warn=1 is reported at done. The sequence still continues and ends with ok=1.
- R7: The START is produced after GUARD_CYC cycles with both lines released. SDA is then pulled low for exactly GUARD_CYC cycles and released, which is the STOP. SCL is never driven low while the sequencer drives SDA low.
- R8: After SDA is released, the sequencer stays busy for exactly FREE_CYC cycles of bus-free time and then reports done with ok=1.
- R9: done is a one-cycle pulse in the first cycle after busy drops. ok and warn are 0 in every cycle in which done is 0.
- R10: A `start_i` pulse while busy has no effect. The run gives exactly one done and one set of clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery trigger pulse |
| eng_scl_oe_i | input | 1 | Byte engine's SCL pull-low enable |
| eng_sda_oe_i | input | 1 | Byte engine's SDA pull-low enable |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | SCL pull-low enable to the pad |
| sda_oe_o | output | 1 | SDA pull-low enable to the pad |
| busy_o | output | 1 | Sequencer owns the pins |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | Recovery succeeded (valid with done) |
| warn_o | output | 1 | A line was low before START (valid with done) |

## Verification
The assertions check on every cycle the properties that hold regardless of stimulus. These are: both lines released on the first busy cycle, SCL never pulled low while the sequencer holds SDA low, done as a single-cycle strobe that comes exactly when busy falls, flags that stay zero outside done, and the clock count reaching its limit before the line check. Only the bench scenarios can show the outcomes that depend on the data. A slave model holds SDA low on chosen clock cycles, and an external pull can hold SCL low. From these the bench shows that an all-low run fails without a START, that a low line at the check gives a warning but still succeeds, and that the guard and bus-free windows have exact lengths. It also shows that a retrigger while busy and a mid-run reset behave at the pins as R10 and R1 require.

// File: rtl/i2c_unwedge_pkg.sv
package i2c_unwedge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RELEASE = 3'd1,
        ST_LOW     = 3'd2,
        ST_HIGH    = 3'd3,
        ST_CHECK   = 3'd4,
        ST_SETUP   = 3'd5,
        ST_START   = 3'd6,
        ST_FREE    = 3'd7
    } unwedge_state_e;

    // index of each line inside a two-wide enable vector
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int N_LINES  = 2;

endpackage

// File: rtl/unwedge_timer.sv
module unwedge_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/unwedge_pin_mux.sv
module unwedge_pin_mux
    import i2c_unwedge_pkg::*;
(
    input  logic               rec_own_i,
    input  logic [N_LINES-1:0] rec_oe_i,
    input  logic [N_LINES-1:0] eng_oe_i,
    output logic [N_LINES-1:0] pin_oe_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign pin_oe_o[g] = rec_own_i ? rec_oe_i[g] : eng_oe_i[g];
    end
endmodule

// File: rtl/unwedge_seq.sv
module unwedge_seq
    import i2c_unwedge_pkg::*;
#(
    parameter int HALF_CYC  = 1250,
    parameter int GUARD_CYC = 250,
    parameter int FREE_CYC  = 15000,
    parameter int N_PULSES  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy_o,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic done_o,
    output logic ok_o,
    output logic warn_o
);
    localparam int MAX_A = (HALF_CYC > GUARD_CYC) ? HALF_CYC : GUARD_CYC;
    localparam int MAX_V = (MAX_A > FREE_CYC) ? MAX_A : FREE_CYC;
    localparam int TW    = $clog2(MAX_V + 1);
    localparam int PW    = $clog2(N_PULSES + 1);

    localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] GUARD_LD = TW'(GUARD_CYC - 1);
    localparam logic [TW-1:0] FREE_LD  = TW'(FREE_CYC - 1);
    localparam logic [PW-1:0] LAST_P   = PW'(N_PULSES);

    typedef struct packed {
        unwedge_state_e st;
        logic [PW-1:0]  pulses;
        logic           seen_hi;
        logic           pend_warn;
        logic           done;
        logic           ok;
        logic           warn;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    unwedge_timer #(.W(TW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ok   = 1'b0;
        r_d.warn = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_RELEASE;
                    r_d.pulses    = '0;
                    r_d.seen_hi   = 1'b0;
                    r_d.pend_warn = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = HALF_LD;
                end
            end
            ST_RELEASE: begin
                if (tmr_zero) begin
                    r_d.st   = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    r_d.st     = ST_HIGH;
                    r_d.pulses = r_q.pulses + 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = HALF_LD;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    r_d.seen_hi = r_q.seen_hi | sda_i;
                    if (r_q.pulses == LAST_P) begin
                        r_d.st = ST_CHECK;
                    end else begin
                        r_d.st   = ST_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = HALF_LD;
                    end
                end
            end
            ST_CHECK: begin
                if (!r_q.seen_hi) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.pend_warn = !(scl_i && sda_i);
                    r_d.st        = ST_SETUP;
                    tmr_load      = 1'b1;
                    tmr_val       = GUARD_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    r_d.st   = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = GUARD_LD;
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    r_d.st   = ST_FREE;
                    tmr_load = 1'b1;
                    tmr_val  = FREE_LD;
                end
            end
            ST_FREE: begin
                if (tmr_zero) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.ok   = 1'b1;
                    r_d.warn = r_q.pend_warn;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, pulses: '0, default: 1'b0};
        else        r_q <= r_d;
    end

    assign busy_o   = (r_q.st != ST_IDLE);
    assign scl_oe_o = (r_q.st == ST_LOW);
    assign sda_oe_o = (r_q.st == ST_START);
    assign done_o   = r_q.done;
    assign ok_o     = r_q.ok;
    assign warn_o   = r_q.warn;

    // R4: the line check is reached only after the full clock count
    a_r4_full_count_before_check: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK) |-> (r_q.pulses == LAST_P));

    // R5: no high sample leads straight to a failing completion
    a_r5_fail_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK && !r_q.seen_hi) |=> (done_o && !ok_o && !warn_o));
endmodule

// File: rtl/i2c_bus_unwedge.sv
module i2c_bus_unwedge
    import i2c_unwedge_pkg::*;
#(
    parameter int HALF_CYC  = 1250,
    parameter int GUARD_CYC = 250,
    parameter int FREE_CYC  = 15000,
    parameter int N_PULSES  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic eng_scl_oe_i,
    input  logic eng_sda_oe_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic ok_o,
    output logic warn_o
);
    logic               seq_busy;
    logic [N_LINES-1:0] rec_oe, eng_oe, pin_oe;

    unwedge_seq #(
        .HALF_CYC  (HALF_CYC),
        .GUARD_CYC (GUARD_CYC),
        .FREE_CYC  (FREE_CYC),
        .N_PULSES  (N_PULSES)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .busy_o   (seq_busy),
        .scl_oe_o (rec_oe[LINE_SCL]),
        .sda_oe_o (rec_oe[LINE_SDA]),
        .done_o   (done_o),
        .ok_o     (ok_o),
        .warn_o   (warn_o)
    );

    assign eng_oe[LINE_SCL] = eng_scl_oe_i;
    assign eng_oe[LINE_SDA] = eng_sda_oe_i;

    unwedge_pin_mux i_mux (
        .rec_own_i (seq_busy),
        .rec_oe_i  (rec_oe),
        .eng_oe_i  (eng_oe),
        .pin_oe_o  (pin_oe)
    );

    assign scl_oe_o = pin_oe[LINE_SCL];
    assign sda_oe_o = pin_oe[LINE_SDA];
    assign busy_o   = seq_busy;

    a_r2_release_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!scl_oe_o && !sda_oe_o));

    a_r7_scl_high_during_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sda_oe_o) |-> !scl_oe_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!ok_o && !warn_o));

    a_r9_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

// File: tb/test_i2c_bus_unwedge.sv
module test_i2c_bus_unwedge;
    localparam int HALF  = 6;
    localparam int GUARD = 4;
    localparam int FREE  = 20;
    localparam int NP    = 9;

    // {slave low mask[8:0], external SCL pull, expected ok, expected warn}
    localparam logic [11:0] VEC [8] = '{
        {9'h000, 1'b0, 1'b1, 1'b0},
        {9'h0FF, 1'b0, 1'b1, 1'b0},
        {9'h1FF, 1'b0, 1'b0, 1'b0},
        {9'h100, 1'b0, 1'b1, 1'b1},
        {9'h0AA, 1'b0, 1'b1, 1'b0},
        {9'h1FE, 1'b0, 1'b1, 1'b1},
        {9'h000, 1'b1, 1'b1, 1'b1},
        {9'h1FF, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic eng_scl = 1'b0, eng_sda = 1'b0;
    logic scl_ext = 1'b0;
    logic [8:0] mask = '0;
    logic scl_oe, sda_oe, busy, done, ok, warn;
    logic scl_line, sda_line, slave_low;

    int checks = 0, fails = 0;

    // monitor state
    logic mon_clr = 1'b0;
    int   idx, scl_rises, scl_low_cyc, starts, overlap, sda_lo_len, free_len;
    int   done_cnt, flag_leak, first_rel_err, busy_at_done;
    logic got_ok, got_warn, busy_seen, prev_scl, prev_sda;

    always #2 clk = ~clk;

    assign slave_low = (idx >= 1 && idx <= 9) ? mask[idx-1] : 1'b0;
    assign scl_line  = !scl_oe && !scl_ext;
    assign sda_line  = !sda_oe && !slave_low;

    i2c_bus_unwedge #(.HALF_CYC(HALF), .GUARD_CYC(GUARD), .FREE_CYC(FREE), .N_PULSES(NP))
    i_i2c_bus_unwedge (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .eng_scl_oe_i(eng_scl), .eng_sda_oe_i(eng_sda),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
        .done_o(done), .ok_o(ok), .warn_o(warn)
    );

    always @(negedge clk) begin
        if (mon_clr) begin
            idx = 0; scl_rises = 0; scl_low_cyc = 0; starts = 0; overlap = 0;
            sda_lo_len = 0; free_len = 0; done_cnt = 0; flag_leak = 0;
            first_rel_err = 0; busy_at_done = 0; got_ok = 0; got_warn = 0;
            busy_seen = 0; prev_scl = 0; prev_sda = 0;
        end else begin
            if (busy) begin
                if (!busy_seen && (scl_oe || sda_oe)) first_rel_err++;
                busy_seen = 1;
                if (scl_oe && !prev_scl) begin scl_rises++; idx++; end
                if (scl_oe) scl_low_cyc++;
                if (sda_oe && !prev_sda) starts++;
                if (sda_oe) sda_lo_len++;
                if (sda_oe && scl_oe) overlap++;
                if (!sda_oe && starts > 0) free_len++;
            end
            if (done) begin
                done_cnt++; got_ok = ok; got_warn = warn;
                if (busy) busy_at_done++;
            end
            if (!done && (ok || warn)) flag_leak++;
            prev_scl = busy ? scl_oe : 1'b0;
            prev_sda = busy ? sda_oe : 1'b0;
        end
    end

    task automatic chk(input logic cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_one(input logic [8:0] m, input logic ext, input logic e_ok, input logic e_warn);
        tick(1);
        mon_clr = 1; mask = m; scl_ext = ext;
        tick(1);
        mon_clr = 0; start = 1;
        tick(1);
        start = 0;
        tick(20);
        start = 1;                       // R10 retrigger while busy
        tick(1);
        start = 0;
        for (int k = 0; k < 2000 && done_cnt == 0; k++) tick(1);
        tick(4);
        chk(first_rel_err == 0, "R2 release on entry", first_rel_err, 0);
        chk(scl_rises == NP, "R3 clock pulse count", scl_rises, NP);
        chk(scl_low_cyc == NP*HALF, "R3 SCL low cycles", scl_low_cyc, NP*HALF);
        chk(got_ok == e_ok, "R4/R5 ok result", got_ok, e_ok);
        chk(got_warn == e_warn, "R6 warn result", got_warn, e_warn);
        chk(starts == (e_ok ? 1 : 0), "R5/R7 START count", starts, e_ok ? 1 : 0);
        chk(overlap == 0, "R7 SCL high during START", overlap, 0);
        chk(sda_lo_len == (e_ok ? GUARD : 0), "R7 START hold", sda_lo_len, e_ok ? GUARD : 0);
        chk(free_len == (e_ok ? FREE : 0), "R8 bus-free time", free_len, e_ok ? FREE : 0);
        chk(done_cnt == 1, "R9/R10 single done", done_cnt, 1);
        chk(busy_at_done == 0 && flag_leak == 0, "R9 done timing and flag gating",
            busy_at_done + flag_leak, 0);
        chk(busy == 0, "R10 no retrigger after done", busy, 0);
        scl_ext = 0; mask = '0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        mon_clr = 1;
        tick(3);
        // reset state, R1 and R9
        chk(busy == 0 && done == 0, "R9 reset idle", {busy, done}, 0);
        chk(ok == 0 && warn == 0, "R9 reset flags", {ok, warn}, 0);
        rst_n = 1;
        tick(2);
        eng_scl = 1; eng_sda = 0;
        tick(1);
        chk(scl_oe == 1 && sda_oe == 0, "R1 idle pass-through a", {scl_oe, sda_oe}, 2);
        eng_scl = 0; eng_sda = 1;
        tick(1);
        chk(scl_oe == 0 && sda_oe == 1, "R1 idle pass-through b", {scl_oe, sda_oe}, 1);

        // engine asserts both enables during runs; the sequencer must own the pins
        eng_scl = 1; eng_sda = 1;
        for (int v = 0; v < 8; v++)
            run_one(VEC[v][11:3], VEC[v][2], VEC[v][1], VEC[v][0]);

        // mid-run reset returns pins to the engine (R1)
        tick(1);
        mon_clr = 1;
        tick(1);
        mon_clr = 0; start = 1;
        tick(1);
        start = 0;
        tick(30);
        chk(busy == 1, "R2 busy during run", busy, 1);
        rst_n = 0;
        tick(2);
        chk(busy == 0 && done == 0, "R1 reset abort idle", {busy, done}, 0);
        chk(scl_oe == 1 && sda_oe == 1, "R1 engine owns after abort", {scl_oe, sda_oe}, 3);
        rst_n = 1;
        eng_scl = 0; eng_sda = 0;
        tick(2);
        run_one(9'h000, 1'b0, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule